// File: doc/BRIEF.md
# DPSK Transmit Bit Request and Differential Encoder

This block is the transmit front end of a DPSK spread-spectrum modem. Each symbol strobe starts a short request sequence toward the data source. The block raises a one-cycle bit-request pulse and samples the serial data input one cycle after the pulse ends. In BPSK mode it takes one bit per symbol. In QPSK mode it takes two bits, the first as I and the second as Q.

At the next symbol strobe, the bits gathered during the previous symbol are differentially encoded against the symbol sent before them. The encoded I/Q pair is held at the outputs for the PN spreader until the following strobe. The mode input is sampled at the strobe and stays with that symbol: it sets the number of requests and the encoding rule used one strobe later.

Strobes must be at least 3 cycles apart in BPSK and at least 5 cycles apart in QPSK. A strobe that arrives while a request sequence is still running updates the encoder but starts no new requests.

Top module: `dpsk_tx_front`

## Requirements
- R1: While reset is asserted and afterwards until the first strobe, `bit_req_o`, `enc_i_o` and `enc_q_o` are all 0.
- R2: A strobe sampled in BPSK mode (`qpsk_i`=0) causes exactly one `bit_req_o` pulse, one cycle wide, high in the cycle right after the strobe edge.
- R3: A strobe sampled in QPSK mode (`qpsk_i`=1) causes exactly two one-cycle `bit_req_o` pulses. The first is high in the cycle after the strobe edge and the second is high two cycles after the first.
- R4: Each requested bit is taken from `ser_data_i` at the clock edge that ends the cycle following its request pulse. In QPSK the first bit is I and the second is Q. Values of `ser_data_i` at other edges have no effect on the outputs.
- R5: `qpsk_i` is only sampled at a strobe. Changing it between strobes does not change the request count or the encoding of that symbol.
- R6: `enc_i_o`/`enc_q_o` change only at an edge where `sym_stb_i` is high. At that edge they take the encoding of the bits captured since the previous strobe, with the mode that was latched at that previous strobe. Before any capture, the staged bits and mode are 0/BPSK.
- R7: For a BPSK symbol, the new `enc_i_o` equals the captured bit XOR the previous `enc_i_o`, and `enc_q_o` equals `enc_i_o`.
- R8: For a QPSK symbol, an (I,Q) pair with I as the MSB maps to a phase index: 00→0, 01→1, 11→2, 10→3. The new output's index is the previous output's index plus the captured pair's index, mod 4. For example, previous 10 with input 01 gives 00, and previous 01 with input 11 gives 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qpsk_i | input | 1 | Mode select, 1 = QPSK, 0 = BPSK, sampled at strobe |
| sym_stb_i | input | 1 | Symbol strobe, one cycle |
| ser_data_i | input | 1 | Serial transmit data |
| bit_req_o | output | 1 | One-cycle request for the next serial bit |
| enc_i_o | output | 1 | Differentially encoded I bit |
| enc_q_o | output | 1 | Differentially encoded Q bit |

## Verification
The assertions check on every cycle that:
- request pulses are one cycle wide and follow each strobe at once;
- the encoded outputs hold steady between strobes;
- each strobe moves the outputs by the XOR rule or by the phase-index addition, applied to the staged bits.

Only the bench's scenarios can show:
- that the right serial edge is sampled and the I/Q order is right, because between requests the data line carries random values;
- that a mode changed between strobes is ignored;
- that the request count per symbol is correct over long runs that mix BPSK and QPSK symbols.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_e;

  typedef struct packed {
    logic i;
    logic q;
  } sym_t;

  // Gray pair <-> phase index; the map is its own inverse
  function automatic logic [1:0] gray_phase(input logic [1:0] v);
    return {v[1], v[1] ^ v[0]};
  endfunction
endpackage

// File: rtl/dpsk_bit_req_seq.sv
module dpsk_bit_req_seq
  import dpsk_pkg::*;
#(
  parameter int unsigned REQ_LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sym_stb_i,
  input  logic qpsk_i,
  output logic bit_req_o,
  output logic sym_mode_o,
  output logic smp_o,
  output logic smp_sel_o
);
  localparam int unsigned CW = $clog2(REQ_LAT + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          sel_q;
  logic          mode_q;
  logic          start;
  logic          smp;

  assign start = sym_stb_i && (state_q == SEQ_IDLE);
  assign smp   = (state_q == SEQ_WAIT) && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_REQ;
          sel_q   <= 1'b0;
          mode_q  <= qpsk_i;
        end
        SEQ_REQ: begin
          state_q <= SEQ_WAIT;
          cnt_q   <= CW'(REQ_LAT);
        end
        SEQ_WAIT: begin
          if (smp) begin
            if (mode_q && !sel_q) begin
              state_q <= SEQ_REQ;
              sel_q   <= 1'b1;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign bit_req_o  = (state_q == SEQ_REQ);
  assign sym_mode_o = mode_q;
  assign smp_o      = smp;
  assign smp_sel_o  = sel_q;
endmodule

// File: rtl/dpsk_bit_capture.sv
module dpsk_bit_capture
  import dpsk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic smp_sel_i,
  input  logic ser_data_i,
  output sym_t stg_o
);
  sym_t stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (smp_i) begin
      if (smp_sel_i) stg_q.q <= ser_data_i;
      else           stg_q.i <= ser_data_i;
    end
  end

  assign stg_o = stg_q;
endmodule

// File: rtl/dpsk_diff_enc.sv
module dpsk_diff_enc
  import dpsk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sym_stb_i,
  input  logic mode_i,
  input  sym_t din_i,
  output sym_t sym_o
);
  sym_t       prev_q;
  sym_t       nxt;
  logic [1:0] ph;
  logic       b;

  always_comb begin
    ph = gray_phase(prev_q) + gray_phase(din_i);
    b  = din_i.i ^ prev_q.i;
    if (mode_i) nxt = sym_t'(gray_phase(ph));
    else        nxt = '{i: b, q: b};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prev_q <= '0;
    else if (sym_stb_i) prev_q <= nxt;
  end

  assign sym_o = prev_q;
endmodule

// File: rtl/dpsk_tx_front.sv
module dpsk_tx_front
  import dpsk_pkg::*;
#(
  parameter int unsigned REQ_LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qpsk_i,
  input  logic sym_stb_i,
  input  logic ser_data_i,
  output logic bit_req_o,
  output logic enc_i_o,
  output logic enc_q_o
);
  logic       stg_mode;
  logic       smp;
  logic       smp_sel;
  sym_t       stg;
  sym_t       enc;
  logic [1:0] stg_bits;

  dpsk_bit_req_seq #(.REQ_LAT(REQ_LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sym_stb_i  (sym_stb_i),
    .qpsk_i     (qpsk_i),
    .bit_req_o  (bit_req_o),
    .sym_mode_o (stg_mode),
    .smp_o      (smp),
    .smp_sel_o  (smp_sel)
  );

  dpsk_bit_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp),
    .smp_sel_i  (smp_sel),
    .ser_data_i (ser_data_i),
    .stg_o      (stg)
  );

  // stg_mode still holds the previous symbol's mode at the strobe edge
  dpsk_diff_enc u_enc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sym_stb_i (sym_stb_i),
    .mode_i    (stg_mode),
    .din_i     (stg),
    .sym_o     (enc)
  );

  assign stg_bits = stg;
  assign enc_i_o  = enc.i;
  assign enc_q_o  = enc.q;
endmodule

// File: rtl/dpsk_tx_front_chk.sv
module dpsk_tx_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sym_stb_i,
  input logic       bit_req_o,
  input logic       enc_i_o,
  input logic       enc_q_o,
  input logic       stg_mode,
  input logic [1:0] stg_bits
);
  a_r2_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |=> !bit_req_o);

  a_r2_req_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_stb_i |=> bit_req_o);

  a_r6_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> $stable({enc_i_o, enc_q_o}));

  a_r7_dbpsk_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_stb_i && !stg_mode) |=>
      (enc_i_o == ($past(enc_i_o) ^ $past(stg_bits[1]))) && (enc_q_o == enc_i_o));

  // R8: phase index of output advances by phase index of staged pair
  a_r8_dqpsk_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_stb_i && stg_mode) |=>
      (({enc_i_o, enc_i_o ^ enc_q_o} - {$past(enc_i_o), $past(enc_i_o) ^ $past(enc_q_o)})
        == {$past(stg_bits[1]), $past(stg_bits[1]) ^ $past(stg_bits[0])}));
endmodule

bind dpsk_tx_front dpsk_tx_front_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sym_stb_i (sym_stb_i),
  .bit_req_o (bit_req_o),
  .enc_i_o   (enc_i_o),
  .enc_q_o   (enc_q_o),
  .stg_mode  (stg_mode),
  .stg_bits  (stg_bits)
);

// File: tb/sim_dpsk_tx_front.sv
`timescale 1ns/1ps
module sim_dpsk_tx_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qpsk = 1'b0;
  logic stb = 1'b0;
  logic ser = 1'b0;
  logic req, eo_i, eo_q;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  bit txq [0:4095];
  int qh = 0;
  int qt = 0;
  bit pend = 0;

  bit       pm = 0;
  bit [1:0] pd = 2'b00;
  bit [1:0] prev = 2'b00;

  always #2 clk = ~clk;

  dpsk_tx_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .qpsk_i(qpsk), .sym_stb_i(stb),
    .ser_data_i(ser), .bit_req_o(req), .enc_i_o(eo_i), .enc_q_o(eo_q)
  );

  // Data source: valid only in the cycle after a request, random elsewhere
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0;
      ser = 1'b0;
    end else if (req) begin
      pend = 1;
      ser = 1'($urandom);
    end else if (pend) begin
      ser = txq[qh];
      qh = qh + 1;
      pend = 0;
    end else begin
      ser = 1'($urandom);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [1:0] idx2pair(input int k);
    case (k)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int pair2idx(input bit [1:0] v);
    int r;
    r = 3;
    for (int k = 0; k < 4; k++) if (idx2pair(k) == v) r = k;
    return r;
  endfunction

  function automatic bit [1:0] model(input bit m, input bit [1:0] d, input bit [1:0] p);
    bit b;
    if (!m) begin
      b = d[1] ^ p[1];
      return {b, b};
    end
    return idx2pair((pair2idx(p) + pair2idx(d)) % 4);
  endfunction

  task automatic symbol(input bit m, input bit [1:0] dat, input int gap);
    bit [1:0] exp;
    int nreq;
    bit moved;
    if (m) begin
      txq[qt] = dat[1]; txq[qt+1] = dat[0]; qt += 2;
    end else begin
      txq[qt] = dat[1]; qt += 1;
    end
    qpsk = m;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    exp = model(pm, pd, prev);
    prev = exp;
    if (pm) chk("R8 R4 R6 dqpsk encode", int'({eo_i, eo_q}), int'(exp));
    else    chk("R7 R4 R6 dbpsk encode", int'({eo_i, eo_q}), int'(exp));
    chk(m ? "R3 first request" : "R2 first request", int'(req), 1);
    nreq = 1;
    moved = 0;
    for (int c = 1; c < gap; c++) begin
      qpsk = 1'($urandom);
      @(negedge clk);
      if (req) nreq++;
      if ({eo_i, eo_q} != exp) moved = 1;
      if (m && c == 2) chk("R3 second request at +2", int'(req), 1);
    end
    chk(m ? "R3 R5 request count" : "R2 R5 request count", nreq, m ? 2 : 1);
    chk("R6 hold between strobes", int'(moved), 0);
    pm = m;
    pd = m ? dat : {dat[1], 1'b0};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset req", int'(req), 0);
    chk("R1 reset enc", int'({eo_i, eo_q}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", int'({req, eo_i, eo_q}), 0);
    // directed: BPSK toggles, then all QPSK inputs from each state
    symbol(0, 2'b10, 6);
    symbol(0, 2'b10, 6);
    symbol(0, 2'b00, 6);
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        symbol(1, idx2pair((d + s) % 4), 6);
    symbol(1, 2'b11, 5);
    symbol(0, 2'b10, 3);
    symbol(1, 2'b01, 5);
    // random mixed traffic
    for (int n = 0; n < 240; n++)
      symbol(1'($urandom), 2'($urandom), 5 + int'($urandom_range(9, 0)));
    symbol(0, 2'b00, 6);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule